// File: doc/BRIEF.md
# Serial Character Transmitter with Preamble and Break

This block frames data characters for an asynchronous serial line and drives a single transmit output. Each character has one low start bit, then 8 or 9 data bits with the least significant bit first, then one high stop bit. A word-length select picks the width. A one-entry holding register takes the next character while the current one shifts out, so characters follow each other with no gap.

Control writes set two levels: the transmit enable and the send-break request. The block turns their changes into special characters. Enabling the transmitter sends a full frame of ones as a preamble. Toggling the enable off and on in the middle of a character queues one all-ones idle character after that character. The break request sends frames of zeros, followed by a single high bit. A separate module enable gates writes to the transmit enable. The bit rate comes from an external one-cycle tick. Each tick moves the line on by exactly one bit.

Top module: `sertx_top`

## Requirements
- R1: After reset, `txd` is 1, `dataEmpty` is 1 and `txDone` is 1. The transmit enable and the break request are both clear.
- R2: A character goes out as a 0 start bit, then the data bits LSB first, then a 1 stop bit. `longWord`=0 sends `dataIn[7:0]`. `longWord`=1 also sends `dataIn[8]`. `txd` changes only on a clock edge where `bitTick` is 1, and it moves by one bit per tick.
- R3: When the transmit enable goes from 0 to 1 and no frame is in progress, the line sends a preamble of all ones before anything else. The preamble is 10 bit times with `longWord`=0 and 11 with `longWord`=1.
- R4: If the transmit enable is cleared during a character, that character finishes and `txd` then stays at 1. A character held in the holding register is not sent, and `dataEmpty` stays 0.
- R5: If the transmit enable is cleared and set again while a character shifts out, one all-ones idle character (10 or 11 bits) follows that character, before any held data.
- R6: A break request that is set and then cleared sends one break frame of zeros (10 or 11 bits). A single 1 bit follows it, and then the next character.
- R7: While the break request stays set, break frames follow each other with no 1 bits between them.
- R8: A break request set after the transmit enable rises, but before the preamble starts, sends the break in place of the preamble. No all-ones preamble follows.
- R9: A control write does not change the transmit enable while `modEn` is 0.
- R10: `dataWr` loads the holding register and drives `dataEmpty` to 0 on the next cycle. The holding register empties when its character starts. A character written during a frame starts on the tick that ends that frame.
- R11: `txDone` is 1 only when no frame, mark bit, held character, preamble, idle character or break is pending. While `txDone` is 1, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modEn | input | 1 | Module enable. Gates writes to the transmit enable |
| ctlWr | input | 1 | Control write strobe |
| ctlTxEn | input | 1 | Transmit enable value for a control write |
| ctlBrk | input | 1 | Break request value for a control write |
| longWord | input | 1 | Word length: 0 = 8 data bits, 1 = 9 data bits |
| dataWr | input | 1 | Strobe that loads the holding register |
| dataIn | input | 9 | Character to send (bit 8 used only for 9-bit words) |
| bitTick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Serial line, idle high |
| dataEmpty | output | 1 | Holding register is empty |
| txDone | output | 1 | Transmitter idle, nothing pending |

## Verification
The bench uses the default base width of 8, so both word lengths are covered: 10-bit and 11-bit frames, preambles and idle characters. It applies a bit tick every 8 clocks. Several control and data writes can therefore fall between two ticks. This makes the timing-sensitive orderings reachable: toggling the enable within one character, and toggling the break before the preamble starts. A break held for exactly three frames shows that back-to-back breaks have no gap and that one mark bit follows them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // What the datapath loads on a bit tick that ends a frame
  typedef enum logic [2:0] {
    LD_NONE  = 3'd0,
    LD_ONES  = 3'd1,
    LD_ZEROS = 3'd2,
    LD_MARK  = 3'd3,
    LD_DATA  = 3'd4
  } loadKind_t;

  typedef struct packed {
    logic      tick;
    loadKind_t kind;
  } dpCmd_t;

endpackage

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              longWord,
  input  logic              dataWr,
  input  logic [BASE_W:0]   dataIn,
  output logic              txd,
  output logic              frameLive,
  output logic              bitsDone,
  output logic              holdFull
);

  localparam int LONG_W    = BASE_W + 1;
  localparam int FRAME_MAX = LONG_W + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shReg;
  logic [FRAME_MAX-1:0] nextFrame;
  logic [CNT_W-1:0]     bitsLeft;
  logic [CNT_W-1:0]     frameLen;
  logic [LONG_W-1:0]    holdReg;
  logic                 lineBit;
  logic                 dataTaken;

  assign bitsDone  = (bitsLeft == '0);
  assign txd       = lineBit;
  assign dataTaken = cmd.tick && bitsDone && (cmd.kind == LD_DATA);

  // Frame assembly: start bit at position 0, stop bit(s) left at one
  always_comb begin
    frameLen  = longWord ? CNT_W'(LONG_W + 2) : CNT_W'(BASE_W + 2);
    nextFrame = '1;
    case (cmd.kind)
      LD_ZEROS: nextFrame = '0;
      LD_DATA: begin
        nextFrame[0] = 1'b0;
        for (int i = 0; i < BASE_W; i++) begin
          nextFrame[i+1] = holdReg[i];
        end
        if (longWord) begin
          nextFrame[BASE_W+1] = holdReg[BASE_W];
        end
      end
      default: nextFrame = '1;
    endcase
  end

  // Shifter: one bit per tick, next frame joins with no gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineBit   <= 1'b1;
      shReg     <= '1;
      bitsLeft  <= '0;
      frameLive <= 1'b0;
    end else if (cmd.tick) begin
      if (!bitsDone) begin
        lineBit  <= shReg[0];
        shReg    <= {1'b1, shReg[FRAME_MAX-1:1]};
        bitsLeft <= bitsLeft - CNT_W'(1);
      end else begin
        case (cmd.kind)
          LD_NONE: begin
            lineBit   <= 1'b1;
            frameLive <= 1'b0;
          end
          LD_MARK: begin
            lineBit   <= 1'b1;
            frameLive <= 1'b1;
          end
          default: begin
            lineBit   <= nextFrame[0];
            shReg     <= {1'b1, nextFrame[FRAME_MAX-1:1]};
            bitsLeft  <= frameLen - CNT_W'(1);
            frameLive <= 1'b1;
          end
        endcase
      end
    end
  end

  // Holding register: a write in the same cycle as a take wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (dataTaken) begin
        holdFull <= 1'b0;
      end
      if (dataWr) begin
        holdReg  <= dataIn;
        holdFull <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   modEn,
  input  logic   ctlWr,
  input  logic   ctlTxEn,
  input  logic   ctlBrk,
  input  logic   bitTick,
  input  logic   frameLive,
  input  logic   bitsDone,
  input  logic   holdFull,
  output dpCmd_t cmd,
  output logic   txEnQ,
  output logic   brkQ,
  output logic   txDone
);

  logic preamblePend;
  logic idlePend;
  logic brkReq;
  logic markPend;
  logic txEnRise;
  logic brkRise;
  logic boundary;
  loadKind_t kind;

  assign txEnRise = ctlWr && modEn && ctlTxEn && !txEnQ;
  assign brkRise  = ctlWr && ctlBrk && !brkQ;
  assign boundary = bitTick && bitsDone;

  // Priority at a frame boundary: break, mark, ones, data
  always_comb begin
    kind = LD_NONE;
    if (boundary && txEnQ) begin
      if (brkQ || brkReq)                 kind = LD_ZEROS;
      else if (markPend)                  kind = LD_MARK;
      else if (preamblePend || idlePend)  kind = LD_ONES;
      else if (holdFull)                  kind = LD_DATA;
      else                                kind = LD_NONE;
    end
  end

  assign cmd.tick = bitTick;
  assign cmd.kind = kind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnQ        <= 1'b0;
      brkQ         <= 1'b0;
      preamblePend <= 1'b0;
      idlePend     <= 1'b0;
      brkReq       <= 1'b0;
      markPend     <= 1'b0;
    end else begin
      if (ctlWr) begin
        if (modEn) begin
          txEnQ <= ctlTxEn;
        end
        brkQ <= ctlBrk;
      end
      if (boundary) begin
        if (!txEnQ) begin
          preamblePend <= 1'b0;
          idlePend     <= 1'b0;
          brkReq       <= 1'b0;
          markPend     <= 1'b0;
        end else begin
          case (kind)
            LD_ZEROS: begin
              brkReq   <= 1'b0;
              markPend <= 1'b1;
            end
            LD_MARK: markPend <= 1'b0;
            LD_ONES: begin
              if (preamblePend) preamblePend <= 1'b0;
              else              idlePend     <= 1'b0;
            end
            default: ;
          endcase
        end
      end
      if (brkRise) begin
        brkReq       <= 1'b1;
        preamblePend <= 1'b0;
      end
      if (txEnRise) begin
        if (frameLive) idlePend     <= 1'b1;
        else           preamblePend <= 1'b1;
      end
    end
  end

  assign txDone = !frameLive && !holdFull && !preamblePend && !idlePend &&
                  !brkReq && !brkQ && !markPend;

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modEn,
  input  logic            ctlWr,
  input  logic            ctlTxEn,
  input  logic            ctlBrk,
  input  logic            longWord,
  input  logic            dataWr,
  input  logic [BASE_W:0] dataIn,
  input  logic            bitTick,
  output logic            txd,
  output logic            dataEmpty,
  output logic            txDone
);

  dpCmd_t cmd;
  logic   frameLive;
  logic   bitsDone;
  logic   holdFull;
  logic   txEnQ;
  logic   brkQ;

  sertx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modEn     (modEn),
    .ctlWr     (ctlWr),
    .ctlTxEn   (ctlTxEn),
    .ctlBrk    (ctlBrk),
    .bitTick   (bitTick),
    .frameLive (frameLive),
    .bitsDone  (bitsDone),
    .holdFull  (holdFull),
    .cmd       (cmd),
    .txEnQ     (txEnQ),
    .brkQ      (brkQ),
    .txDone    (txDone)
  );

  sertx_dp #(.BASE_W(BASE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .longWord  (longWord),
    .dataWr    (dataWr),
    .dataIn    (dataIn),
    .txd       (txd),
    .frameLive (frameLive),
    .bitsDone  (bitsDone),
    .holdFull  (holdFull)
  );

  assign dataEmpty = !holdFull;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rstN,
  input logic modEn,
  input logic dataWr,
  input logic bitTick,
  input logic txd,
  input logic dataEmpty,
  input logic txDone,
  input logic txEnQ,
  input logic brkQ,
  input logic frameLive
);

  // R11: nothing pending means the line rests high
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txd);

  // R2: the line moves only on a bit tick
  p_line_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable(txd));

  // R9: the enable keeps its value while the module is disabled
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !modEn |=> $stable(txEnQ));

  // R10: a data write leaves the block busy with a full register
  p_write_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (!dataEmpty && !txDone));

  // R4: disabled with no frame in flight keeps the line high
  p_disabled_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnQ && !frameLive) |=> txd);

  // R7: a held break never reports completion
  p_break_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    brkQ |-> !txDone);

endmodule

bind sertx_top sertx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modEn     (modEn),
  .dataWr    (dataWr),
  .bitTick   (bitTick),
  .txd       (txd),
  .dataEmpty (dataEmpty),
  .txDone    (txDone),
  .txEnQ     (txEnQ),
  .brkQ      (brkQ),
  .frameLive (frameLive)
);

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modEn = 1'b0;
  logic       ctlWr = 1'b0;
  logic       ctlTxEn = 1'b0;
  logic       ctlBrk = 1'b0;
  logic       longWord = 1'b0;
  logic       dataWr = 1'b0;
  logic [8:0] dataIn = '0;
  logic       bitTick = 1'b0;
  logic       txd;
  logic       dataEmpty;
  logic       txDone;

  int  nChk = 0;
  int  nFail = 0;
  int  cyc = 0;
  bit  monOn = 1'b0;
  bit  finished = 1'b0;
  bit  tickSeen = 1'b0;
  bit  enShadow = 1'b0;
  bit  expQ[$];
  string phaseTag = "R1";

  sertx_top u0 (
    .clk(clk), .rstN(rstN), .modEn(modEn), .ctlWr(ctlWr), .ctlTxEn(ctlTxEn),
    .ctlBrk(ctlBrk), .longWord(longWord), .dataWr(dataWr), .dataIn(dataIn),
    .bitTick(bitTick), .txd(txd), .dataEmpty(dataEmpty), .txDone(txDone)
  );

  always #2 clk = ~clk;

  // Bit tick: one cycle in every eight
  always @(negedge clk) begin
    cyc = cyc + 1;
    bitTick = ((cyc % 8) == 0);
  end

  always @(posedge clk) tickSeen <= bitTick;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: after every tick compare the line with the next expected bit
  always @(negedge clk) begin
    if (monOn && tickSeen) begin
      bit e;
      e = 1'b1;
      if (expQ.size() > 0) e = expQ.pop_front();
      chk(txd === e, {phaseTag, " line bit"}, int'(txd), int'(e));
    end
  end

  task automatic waitTick();
    do @(posedge clk); while (!bitTick);
    @(negedge clk);
    #1;
  endtask

  task automatic ctl(input bit en, input bit brk);
    ctlWr = 1'b1; ctlTxEn = en; ctlBrk = brk;
    @(posedge clk); #1;
    ctlWr = 1'b0;
    if (modEn) enShadow = en;
  endtask

  task automatic writeData(input logic [8:0] d);
    dataWr = 1'b1; dataIn = d;
    @(posedge clk); #1;
    dataWr = 1'b0;
  endtask

  task automatic pushRun(input bit v, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(v);
  endtask

  task automatic pushFrame(input logic [8:0] d, input bit wide);
    expQ.push_back(1'b0);
    for (int i = 0; i < (wide ? 9 : 8); i++) expQ.push_back(d[i]);
    expQ.push_back(1'b1);
  endtask

  task automatic drain();
    while (expQ.size() > 0) waitTick();
    waitTick();
    waitTick();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(txd === 1'b1, "R1 txd", int'(txd), 1);
    chk(dataEmpty === 1'b1, "R1 dataEmpty", int'(dataEmpty), 1);
    chk(txDone === 1'b1, "R1 txDone", int'(txDone), 1);
    rstN = 1'b1;
    monOn = 1'b1;

    // R9: enable write ignored while module disabled; data stays held
    phaseTag = "R9";
    waitTick();
    ctl(1'b1, 1'b0);
    writeData(9'h055);
    repeat (12) waitTick();
    chk(dataEmpty === 1'b0, "R9 dataEmpty", int'(dataEmpty), 0);
    chk(txDone === 1'b0, "R9 txDone", int'(txDone), 0);

    // R3: preamble of 10 ones, then the held character
    phaseTag = "R3";
    modEn = 1'b1;
    waitTick();
    pushRun(1'b1, 10);
    pushFrame(9'h055, 1'b0);
    ctl(1'b1, 1'b0);
    waitTick();
    chk(txDone === 1'b0, "R11 busy in preamble", int'(txDone), 0);
    drain();
    chk(txDone === 1'b1, "R11 done after frame", int'(txDone), 1);
    chk(dataEmpty === 1'b1, "R10 empty after send", int'(dataEmpty), 1);

    // R2 / R10: 9-bit words, second written mid-frame, back to back
    phaseTag = "R2";
    longWord = 1'b1;
    waitTick();
    pushFrame(9'h1A5, 1'b1);
    writeData(9'h1A5);
    waitTick();
    pushFrame(9'h0F3, 1'b1);
    writeData(9'h0F3);
    chk(dataEmpty === 1'b0, "R10 dataEmpty after write", int'(dataEmpty), 0);
    drain();
    chk(txDone === 1'b1, "R11 done after 9-bit", int'(txDone), 1);

    // R3: 11-bit preamble for long words
    phaseTag = "R3";
    waitTick();
    ctl(1'b0, 1'b0);
    ctl(1'b1, 1'b0);
    writeData(9'h100);
    pushRun(1'b1, 11);
    pushFrame(9'h100, 1'b1);
    drain();

    // R4: disable mid-character, finish it, hold the next one
    phaseTag = "R4";
    longWord = 1'b0;
    waitTick();
    pushFrame(9'h0C3, 1'b0);
    writeData(9'h0C3);
    repeat (3) waitTick();
    ctl(1'b0, 1'b0);
    writeData(9'h03C);
    repeat (16) waitTick();
    chk(dataEmpty === 1'b0, "R4 held data not sent", int'(dataEmpty), 0);
    chk(txd === 1'b1, "R4 line idle", int'(txd), 1);
    pushRun(1'b1, 10);
    pushFrame(9'h03C, 1'b0);
    ctl(1'b1, 1'b0);
    drain();

    // R5: off then on during a character queues an idle character
    phaseTag = "R5";
    waitTick();
    pushFrame(9'h081, 1'b0);
    writeData(9'h081);
    repeat (2) waitTick();
    ctl(1'b0, 1'b0);
    ctl(1'b1, 1'b0);
    writeData(9'h07E);
    pushRun(1'b1, 10);
    pushFrame(9'h07E, 1'b0);
    drain();

    // R6: short break request, mark bit, then data
    phaseTag = "R6";
    waitTick();
    ctl(1'b1, 1'b1);
    ctl(1'b1, 1'b0);
    writeData(9'h05A);
    pushRun(1'b0, 10);
    expQ.push_back(1'b1);
    pushFrame(9'h05A, 1'b0);
    drain();

    // R8: break toggled before the preamble starts replaces it
    phaseTag = "R8";
    waitTick();
    ctl(1'b0, 1'b0);
    ctl(1'b1, 1'b0);
    ctl(1'b1, 1'b1);
    ctl(1'b1, 1'b0);
    writeData(9'h0A5);
    pushRun(1'b0, 10);
    expQ.push_back(1'b1);
    pushFrame(9'h0A5, 1'b0);
    drain();

    // R7: held break for three frames, no ones between them
    phaseTag = "R7";
    waitTick();
    pushRun(1'b0, 30);
    expQ.push_back(1'b1);
    ctl(1'b1, 1'b1);
    repeat (15) waitTick();
    chk(txDone === 1'b0, "R7 busy during break", int'(txDone), 0);
    repeat (15) waitTick();
    ctl(1'b1, 1'b0);
    drain();
    chk(txd === 1'b1, "R7 line high after break", int'(txd), 1);
    chk(txDone === 1'b1, "R11 done after break", int'(txDone), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule